// File: doc/BRIEF.md
# Segmented Pixel Time-to-Digital Converter

This block measures, for one pixel of a photon-counting array, the time between an arming pulse and the first avalanche. The measurement is split into three segments. The least significant segment comes from a bus of equally spaced clock phases that every pixel in the array shares. The pixel records that bus as a thermometer code at the moment of the hit. The middle segment is a small per-pixel counter that divides the reference clock. The most significant segment is a per-pixel maximal-length LFSR, stepped once per divided-clock period, which extends the range to 13 bits.

The counters are not captured at the hit. They keep running for one divided-clock period and then freeze. The fine code then decides whether one reference cycle has to be taken back. Because of this, no segment boundary can be latched half-updated. The frozen LFSR, middle counter and fine bits together form one 13-bit register chain. After the frame a load pulse puts that chain into plain shift mode, and the chain shifts the word out serially, MSB first. A pixel that saw no hit reports the all-zero word, which the LFSR cannot otherwise reach.

Top module: `tdc_pixel_seg`

## Requirements
- R1: While reset is low and after its release, `ser_vld_o` stays 0 until a word has been requested with `load_i`.
- R2: The fine code counts the run of consecutive 1 bits in `phase_i` that starts at bit 0, sampled at the clock edge that sees `stop_i`. Bits above the first 0 have no effect, so bubbles are ignored. With s the number of rising edges from the edge that samples `start_i` to the one that samples `stop_i`, and n that count (0 to 8), the measured time in 0.5-step LSBs is T = 8*(s-1) + n - 1.
- R3: A hit is reported as the 13-bit word {C[7:0], M[1:0], F[2:0]}. Here F = T mod 8 and M = (T/8) mod 4. C is the LFSR state reached after T/32 steps from seed 8'h01, where each step maps x to {x[6:0], x[7]^x[5]^x[4]^x[3]}. C is never zero.
- R4: Only the first stop after an arm counts. Later stops in the same frame change nothing, and a stop on the same edge as a start is ignored. After the stop the counters run on for one divided period (4 cycles), or 3 cycles when n = 0, and then hold.
- R5: The decoded time never decreases as the stop moves later, including across middle-counter wraps and LFSR steps.
- R6: The all-zero word is reported when there was no stop before the load, when the stop comes 1020 or more edges after start, or when the interval gives T beyond 8127 (the counters would wrap). T = 8127 is still reported as a hit.
- R7: `load_i`, accepted after an armed frame, makes `ser_vld_o` high for exactly 13 cycles starting the cycle after the load edge, with `ser_o` carrying word bit 12 first down to bit 0.
- R8: A load before any arm or while shifting is ignored. A stop while not armed is ignored. A start while shifting is ignored. In every other state a start re-arms the pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arming pulse, one cycle |
| stop_i | input | 1 | Avalanche hit pulse, one cycle |
| phase_i | input | 8 | Shared phase bus sampled as thermometer code |
| load_i | input | 1 | Frame end, starts serial read-out |
| ser_o | output | 1 | Serial word bit, MSB first |
| ser_vld_o | output | 1 | High while a word bit is on `ser_o` |

## Verification
The assertions assume that each control input is a one-cycle pulse taken from the same clock. They also assume that the frame sequencing waits at least six cycles after a stop before it loads, so that a load never arrives while the counters are still running past the hit. The stimulus drives all pulses on the falling edge and always inserts that gap. It sweeps the stop edge and the thermometer pattern together so that consecutive cases step one LSB across every middle and coarse boundary. It also places the last few stops right at the wrap limit.

// File: rtl/tdc_seg_pkg.sv
package tdc_seg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RUN,
      ST_DELAY,
      ST_DONE,
      ST_NOHIT,
      ST_SHIFT
   } seg_state_e;

endpackage

// File: rtl/tdc_therm_dec.sv
// Converts the sampled phase bus to the length of its leading run of ones.
module tdc_therm_dec #(
   parameter int PHASES = 8,
   parameter int CNT_W  = 4
) (
   input  logic [PHASES-1:0] phase_i,
   output logic [CNT_W-1:0]  ones_o
);

   logic [PHASES-1:0] run;

   generate
      if ((1 << CNT_W) <= PHASES) begin : g_bad_width
         $error("tdc_therm_dec: CNT_W too narrow for PHASES");
      end
      for (genvar i = 0; i < PHASES; i++) begin : g_run
         if (i == 0) begin : g_first
            assign run[i] = phase_i[i];
         end else begin : g_next
            assign run[i] = run[i-1] & phase_i[i];
         end
      end
   endgenerate

   always_comb begin
      ones_o = '0;
      for (int i = 0; i < PHASES; i++) begin
         ones_o = ones_o + CNT_W'(run[i]);
      end
   end

endmodule

// File: rtl/tdc_seg_chain.sv
// Middle divider, coarse LFSR and fine bits as one counting / holding / shifting chain.
module tdc_seg_chain #(
   parameter int                FINE_W = 3,
   parameter int                MID_W  = 2,
   parameter int                CRS_W  = 8,
   parameter logic [CRS_W-1:0]  TAPS   = 8'hB8,
   parameter logic [CRS_W-1:0]  SEED   = 8'h01
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              seed_i,
   input  logic              clr_i,
   input  logic              shift_i,
   input  logic              cnt_i,
   input  logic              fine_we_i,
   input  logic [FINE_W-1:0] fine_i,
   output logic [CRS_W-1:0]  crs_o,
   output logic [MID_W-1:0]  mid_o,
   output logic [FINE_W-1:0] fine_o,
   output logic              msb_o,
   output logic              last_o
);

   localparam int WORD_W = CRS_W + MID_W + FINE_W;

   function automatic logic [CRS_W-1:0] lfsr_fwd(input logic [CRS_W-1:0] s);
      return {s[CRS_W-2:0], ^(s & TAPS)};
   endfunction

   function automatic logic [CRS_W-1:0] lfsr_back(input logic [CRS_W-1:0] s);
      return {s[0] ^ (^(s[CRS_W-1:1] & TAPS[CRS_W-2:0])), s[CRS_W-1:1]};
   endfunction

   // Seed one step early: the delayed capture always adds one full divided period.
   localparam logic [CRS_W-1:0] PRE_C  = lfsr_back(SEED);
   localparam logic [CRS_W-1:0] LAST_C = lfsr_back(PRE_C);

   generate
      if (CRS_W < 2) begin : g_bad_crs
         $error("tdc_seg_chain: CRS_W must be at least 2");
      end
      if (!TAPS[CRS_W-1]) begin : g_bad_taps
         $error("tdc_seg_chain: top tap bit must be set");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("tdc_seg_chain: SEED must be nonzero");
      end
   endgenerate

   logic [CRS_W-1:0]  crs_q;
   logic [MID_W-1:0]  mid_q;
   logic [FINE_W-1:0] fine_q;
   logic [WORD_W-1:0] word_shl;

   assign word_shl = {crs_q, mid_q, fine_q} << 1;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         crs_q  <= '0;
         mid_q  <= '0;
         fine_q <= '0;
      end else if (seed_i) begin
         crs_q  <= PRE_C;
         mid_q  <= '0;
         fine_q <= '0;
      end else if (clr_i) begin
         crs_q  <= '0;
         mid_q  <= '0;
         fine_q <= '0;
      end else if (shift_i) begin
         {crs_q, mid_q, fine_q} <= word_shl;
      end else begin
         if (cnt_i) begin
            mid_q <= mid_q + 1'b1;
            if (&mid_q) begin
               crs_q <= lfsr_fwd(crs_q);
            end
         end
         if (fine_we_i) begin
            fine_q <= fine_i;
         end
      end
   end

   assign crs_o  = crs_q;
   assign mid_o  = mid_q;
   assign fine_o = fine_q;
   assign msb_o  = crs_q[CRS_W-1];
   assign last_o = (crs_q == LAST_C) && (&mid_q);

endmodule

// File: rtl/tdc_pixel_seg.sv
module tdc_pixel_seg
   import tdc_seg_pkg::*;
#(
   parameter int               FINE_W   = 3,
   parameter int               MID_W    = 2,
   parameter int               CRS_W    = 8,
   parameter logic [CRS_W-1:0] CRS_TAPS = 8'hB8,
   parameter logic [CRS_W-1:0] CRS_SEED = 8'h01,
   localparam int              PHASES   = 1 << FINE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [PHASES-1:0] phase_i,
   input  logic              load_i,
   output logic              ser_o,
   output logic              ser_vld_o
);

   localparam int DIV    = 1 << MID_W;
   localparam int WORD_W = CRS_W + MID_W + FINE_W;
   localparam int CNT_W  = FINE_W + 1;
   localparam int BIT_W  = $clog2(WORD_W);
   localparam logic [MID_W-1:0] DLY_FULL  = MID_W'(DIV - 1);
   localparam logic [MID_W-1:0] DLY_SHORT = MID_W'(DIV - 2);

   generate
      if (MID_W < 1 || FINE_W < 1) begin : g_bad_split
         $error("tdc_pixel_seg: MID_W and FINE_W must be at least 1");
      end
   endgenerate

   seg_state_e        state_q, state_d;
   logic [MID_W-1:0]  dly_q;
   logic [BIT_W-1:0]  bit_q;
   logic [CNT_W-1:0]  ones;
   logic [FINE_W-1:0] fine_val;
   logic              seed, clr, shift, cnt_en, fine_we;
   logic [CRS_W-1:0]  crs;
   logic [MID_W-1:0]  mid;
   logic [FINE_W-1:0] fine;
   logic              msb, last;

   tdc_therm_dec #(.PHASES(PHASES), .CNT_W(CNT_W)) therm_i (
      .phase_i (phase_i),
      .ones_o  (ones)
   );

   // Empty run: the hit came before the counted edge, so report the previous cycle's top slot.
   assign fine_val = (ones == '0) ? '1 : FINE_W'(ones - 1'b1);

   tdc_seg_chain #(
      .FINE_W (FINE_W), .MID_W (MID_W), .CRS_W (CRS_W),
      .TAPS   (CRS_TAPS), .SEED (CRS_SEED)
   ) chain_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .seed_i    (seed),
      .clr_i     (clr),
      .shift_i   (shift),
      .cnt_i     (cnt_en),
      .fine_we_i (fine_we),
      .fine_i    (fine_val),
      .crs_o     (crs),
      .mid_o     (mid),
      .fine_o    (fine),
      .msb_o     (msb),
      .last_o    (last)
   );

   always_comb begin
      state_d = state_q;
      seed    = 1'b0;
      clr     = 1'b0;
      shift   = 1'b0;
      cnt_en  = 1'b0;
      fine_we = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               seed    = 1'b1;
               state_d = ST_RUN;
            end
         end
         ST_RUN: begin
            if (start_i) begin
               seed = 1'b1;
            end else if (load_i) begin
               clr     = 1'b1;
               state_d = ST_SHIFT;
            end else if (last) begin
               state_d = ST_NOHIT;
            end else begin
               cnt_en = 1'b1;
               if (stop_i) begin
                  fine_we = 1'b1;
                  state_d = ST_DELAY;
               end
            end
         end
         ST_DELAY: begin
            if (start_i) begin
               seed    = 1'b1;
               state_d = ST_RUN;
            end else if (dly_q == '0) begin
               state_d = ST_DONE;
            end else if (last) begin
               state_d = ST_NOHIT;
            end else begin
               cnt_en = 1'b1;
            end
         end
         ST_DONE: begin
            if (start_i) begin
               seed    = 1'b1;
               state_d = ST_RUN;
            end else if (load_i) begin
               state_d = ST_SHIFT;
            end
         end
         ST_NOHIT: begin
            if (start_i) begin
               seed    = 1'b1;
               state_d = ST_RUN;
            end else if (load_i) begin
               clr     = 1'b1;
               state_d = ST_SHIFT;
            end
         end
         ST_SHIFT: begin
            shift = 1'b1;
            if (bit_q == BIT_W'(WORD_W - 1)) begin
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         dly_q   <= '0;
         bit_q   <= '0;
      end else begin
         state_q <= state_d;
         if (fine_we) begin
            dly_q <= (ones == '0) ? DLY_SHORT : DLY_FULL;
         end else if (state_q == ST_DELAY && cnt_en) begin
            dly_q <= dly_q - 1'b1;
         end
         if (state_q != ST_SHIFT) begin
            bit_q <= '0;
         end else begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   assign ser_vld_o = (state_q == ST_SHIFT);
   assign ser_o     = ser_vld_o & msb;

endmodule

// File: rtl/tdc_pixel_seg_chk.sv
module tdc_pixel_seg_chk
   import tdc_seg_pkg::*;
#(
   parameter int FINE_W = 3,
   parameter int MID_W  = 2,
   parameter int CRS_W  = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              load_i,
   input logic              ser_vld_o,
   input seg_state_e        state_q,
   input logic [CRS_W-1:0]  crs,
   input logic [MID_W-1:0]  mid,
   input logic [FINE_W-1:0] fine
);

   localparam int WORD_W = CRS_W + MID_W + FINE_W;

   logic [7:0] run_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q <= '0;
      end else if (ser_vld_o) begin
         run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   // R7: a read-out never exceeds the word length
   assert_shift_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ser_vld_o |-> (run_q < 8'(WORD_W)));

   // R7: a read-out ends only after the full word
   assert_shift_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ser_vld_o) |-> (run_q == 8'(WORD_W)));

   // R7: a read-out begins only after a load
   assert_shift_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ser_vld_o) |-> $past(load_i));

   // R8: a load on an unarmed pixel produces nothing
   assert_idle_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && load_i) |=> !ser_vld_o);

   // R4: once captured, the segments hold
   assert_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_DONE && $past(state_q) == ST_DONE) |->
         ($stable(crs) && $stable(mid) && $stable(fine)));

   // R3: a held hit never shows the forbidden all-zero coarse state
   assert_hit_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_DONE) |-> (crs != '0));

endmodule

bind tdc_pixel_seg tdc_pixel_seg_chk #(
   .FINE_W (FINE_W), .MID_W (MID_W), .CRS_W (CRS_W)
) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .load_i    (load_i),
   .ser_vld_o (ser_vld_o),
   .state_q   (state_q),
   .crs       (crs),
   .mid       (mid),
   .fine      (fine)
);

// File: tb/tdc_pixel_seg_tb_top.sv
module tdc_pixel_seg_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       start_i = 1'b0;
   logic       stop_i = 1'b0;
   logic [7:0] phase_i = 8'h00;
   logic       load_i = 1'b0;
   logic       ser_o;
   logic       ser_vld_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk_i = ~clk_i;

   tdc_pixel_seg dut_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_i),
      .stop_i    (stop_i),
      .phase_i   (phase_i),
      .load_i    (load_i),
      .ser_o     (ser_o),
      .ser_vld_o (ser_vld_o)
   );

   // behavioural reference: 0 idle, 1 armed, 2 hit held, 3 no hit, 4 shifting
   int          m_st = 0;
   int          m_edges = 0;
   int          m_bit = 0;
   int          m_t = -1;
   logic [12:0] m_word = '0;
   logic [12:0] rx = '0;
   string       cur_req = "R1";
   bit          mono = 1'b0;
   int          last_t = -1;

   task automatic chk(input bit ok, input string req, input int act, input int exp_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   function automatic int lstep(input int s);
      int b;
      b = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
      return ((s << 1) & 8'hFE) | b;
   endfunction

   function automatic logic [12:0] enc(input int t);
      int c = 1;
      for (int i = 0; i < t / 32; i++) c = lstep(c);
      return {8'(c), 2'((t / 8) % 4), 3'(t % 8)};
   endfunction

   function automatic int dec(input logic [12:0] w);
      int c = 1;
      for (int q = 0; q < 255; q++) begin
         if (c == int'(w[12:5])) return q * 32 + int'(w[4:3]) * 8 + int'(w[2:0]);
         c = lstep(c);
      end
      return -1;
   endfunction

   function automatic int run_ones(input logic [7:0] ph);
      int n = 0;
      while (n < 8 && ph[n]) n++;
      return n;
   endfunction

   task automatic step(input bit st, input bit sp, input logic [7:0] ph, input bit ld);
      logic [12:0] w;
      int d;
      int n;
      int f;
      @(negedge clk_i);
      chk(ser_vld_o === (m_st == 4), "R7 valid", int'(ser_vld_o), int'(m_st == 4));
      if (m_st == 4 && ser_vld_o === 1'b1) begin
         chk(ser_o === m_word[12 - m_bit], cur_req, int'(ser_o), int'(m_word[12 - m_bit]));
         w  = {rx[11:0], ser_o};
         rx = w;
         if (m_bit == 12) begin
            chk(w == m_word, cur_req, int'(w), int'(m_word));
            if (m_t >= 0) begin
               d = dec(w);
               chk(d == m_t, cur_req, d, m_t);
               if (mono) begin
                  chk(d >= last_t, "R5", d, last_t);
                  last_t = d;
               end
            end
         end
      end
      start_i = st;
      stop_i  = sp;
      phase_i = ph;
      load_i  = ld;
      if (!rst_ni) begin
         m_st = 0;
      end else if (m_st == 4) begin
         if (m_bit == 12) m_st = 0;
         else m_bit++;
      end else if (st) begin
         m_st = 1;
         m_edges = 0;
      end else begin
         case (m_st)
            1: begin
               m_edges++;
               if (ld) begin
                  m_word = '0; m_t = -1; m_st = 4; m_bit = 0;
               end else if (m_edges >= 1020) begin
                  m_st = 3;
               end else if (sp) begin
                  n = run_ones(ph);
                  f = (n == 0) ? m_edges + 2 : m_edges + 3;
                  if (f > 1019) begin
                     m_st = 3;
                  end else begin
                     m_t = 8 * (m_edges - 1) + n - 1;
                     m_word = enc(m_t);
                     m_st = 2;
                  end
               end
            end
            2: if (ld) begin m_st = 4; m_bit = 0; end
            3: if (ld) begin m_word = '0; m_t = -1; m_st = 4; m_bit = 0; end
            default: ;
         endcase
      end
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) step(0, 0, 8'h00, 0);
   endtask

   task automatic frame(input int s, input logic [7:0] ph, input bit do_stop);
      step(1, 0, 8'h00, 0);
      idle(s - 1);
      step(0, do_stop, ph, 0);
      idle(6);
      step(0, 0, 8'h00, 1);
      idle(14);
   endtask

   initial begin
      #(200000 * 8);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(5);
      step(0, 0, 8'h00, 0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      chk(ser_vld_o === 1'b0, "R1", int'(ser_vld_o), 0);

      // R8: stop and load with nothing armed
      cur_req = "R8";
      step(0, 1, 8'hFF, 0);
      step(0, 0, 8'h00, 1);
      idle(16);

      // R2: thermometer patterns incl. bubble, empty and full runs
      cur_req = "R2";
      frame(7, 8'h00, 1);
      frame(7, 8'h01, 1);
      frame(7, 8'h07, 1);
      frame(7, 8'hB7, 1);
      frame(7, 8'hFF, 1);
      frame(7, 8'hFE, 1);
      frame(7, 8'h7F, 1);

      // R3 / R5: one-LSB sweep across middle wraps and coarse steps
      cur_req = "R3";
      mono = 1'b1;
      last_t = -1;
      for (int s = 2; s <= 40; s++) begin
         for (int n = 0; n <= 8; n++) frame(s, 8'((1 << n) - 1), 1);
      end
      mono = 1'b0;

      // R4: second stop ignored, stop with start ignored
      cur_req = "R4";
      step(1, 1, 8'hFF, 0);
      idle(8);
      step(0, 1, 8'h0F, 0);
      idle(1);
      step(0, 1, 8'hFF, 0);
      idle(6);
      step(0, 0, 8'h00, 1);
      idle(14);

      // R6: no hit, late hit after timeout, range edges
      cur_req = "R6";
      frame(20, 8'h00, 0);
      frame(1030, 8'h0F, 1);
      frame(1016, 8'hFF, 1);
      frame(1017, 8'hFF, 1);
      frame(1017, 8'h00, 1);

      // R8: start and load during read-out are ignored
      cur_req = "R8";
      frame(3, 8'h03, 1);
      step(1, 0, 8'h00, 0);
      idle(5);
      step(0, 1, 8'h0F, 0);
      idle(6);
      step(0, 0, 8'h00, 1);
      idle(3);
      step(1, 0, 8'h00, 1);
      idle(12);
      step(0, 0, 8'h00, 1);
      idle(16);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule